// File: doc/BRIEF.md
# I2C target with status flags

This block is the target (slave) side of a two-wire serial bus, with a small register port for software. It filters and samples the clock and data lines and finds START, repeated START and STOP. It compares each 7-bit address with a programmable own address. It can also answer the all-zero general call address. Received bytes land in a receive holding register. Bytes for the master are taken from a transmit holding register. The block drives the bus only by pulling a line low: `sda_oe_o` pulls data low and `scl_oe_o` pulls clock low.

Software sees six status flags, each with its own set and clear rule:

- The access flag follows the latest address comparison and drops on STOP or on a master NACK.
- The direction flag only carries meaning while access is set.
- The general-call and not-acknowledged flags clear when the status register is read.
- Receive-ready clears when the data register is read.
- Transmit-ready falls when software loads a byte. It rises again only after that byte's acknowledge bit has been sampled.

While a read is waiting for data, the block holds the clock low until software loads a byte.

Top module: `i2c_target_stat`

## Requirements
- R1: After START, an address byte whose upper 7 bits equal the own address (register 0, bits 6:0) is acknowledged. The block pulls data low during the ninth clock. Status bit 0 (access) becomes 1 and status bit 1 (direction) takes the R/W bit, where 1 means a master read. Status is register 2.
- R2: An address byte that matches neither the own address nor an enabled general call is not acknowledged, and the access bit stays 0.
- R3: A STOP condition clears the access bit.
- R4: The address byte 0x00 (address 0, write) is acknowledged and sets status bit 2 only when control register 1 bit 0 is 1. In that case the access bit is 0. The byte 0x01 is never acknowledged. Reading status clears bit 2.
- R5: In a master write, each received byte is acknowledged, copied to the data register (register 3) and sets status bit 4. Reading register 3 clears bit 4.
- R6: Writing register 3 clears status bit 3 (transmit-ready), which is 1 after reset. In a master read, the byte is sent MSB first. Bit 3 returns to 1 only once the master's acknowledge bit has been sampled.
- R7: In a master read, the clock is held low after an acknowledge while no new byte is pending, and transmit-ready is then 1. The clock is released once register 3 is written.
- R8: A master NACK after a sent byte sets status bit 5 and clears the access bit. No later byte is driven until the next START. Reading status clears bit 5.
- R9: A repeated START while addressed leaves the access bit unchanged until the new address byte completes. The bit then follows the new comparison.
- R10: After reset, status reads 0x08 and neither bus line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe_o | output | 1 | Pull bus clock low |
| sda_oe_o | output | 1 | Pull bus data low |
| reg_addr_i | input | 2 | Register select: 0 own address, 1 control, 2 status, 3 data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |

## Verification
On every cycle, the assertions check the following:

- STOP always removes access, and a repeated START leaves it untouched.
- A master NACK leaves the data line released with access cleared.
- A status read clears the general-call and NACK flags, and a data read clears receive-ready.
- A data write drops transmit-ready, and transmit-ready rises only after an acknowledge sample.
- The clock is held low only while transmit-ready is 1.

Only the bench scenarios show the end-to-end behaviour: which address bytes are acknowledged, the bit order of sent and received bytes, that the clock is released after a late load, and that nothing is driven after a NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam logic [1:0] REG_OWN  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int ST_ACC = 0;
  localparam int ST_RD  = 1;
  localparam int ST_GC  = 2;
  localparam int ST_TXR = 3;
  localparam int ST_RXR = 4;
  localparam int ST_NAK = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_ACK_B, S_RX, S_TX_LOAD, S_TX, S_TX_ACK, S_TX_ACKF
  } eng_state_e;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int WIDTH    = 2,
  parameter int FILT_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    // output follows only after FILT_LEN stable samples
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], din_i[g]};
        if (sync_q[1] == out_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign dout_o[g] = out_q;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          gc_en_i,
  input  logic          tx_pend_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          sda_oe_o,
  output logic          scl_oe_o,
  output logic          acc_o,
  output logic          rd_o,
  output logic          gc_hit_o,
  output logic          rx_stb_o,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_load_o,
  output logic          tx_done_o,
  output logic          nack_hit_o
);
  localparam int BW = $clog2(DW);

  eng_state_e    state_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          scl_q, sda_q;

  logic scl_rise, scl_fall, start_c, stop_c, last_bit, own_hit, gc_addr;
  logic [DW-1:0] sh_in;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign sh_in    = {sh_q[DW-2:0], sda_i};
  assign last_bit = (bit_q == BW'(DW - 1));
  assign own_hit  = (sh_in[DW-1:1] == own_addr_i);
  assign gc_addr  = (sh_in[DW-1:1] == '0) & ~sh_in[0] & gc_en_i;

  assign scl_oe_o  = (state_q == S_TX_LOAD) & ~tx_pend_i;
  assign rx_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      sda_oe_o   <= 1'b0;
      acc_o      <= 1'b0;
      rd_o       <= 1'b0;
      gc_hit_o   <= 1'b0;
      rx_stb_o   <= 1'b0;
      tx_load_o  <= 1'b0;
      tx_done_o  <= 1'b0;
      nack_hit_o <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      gc_hit_o   <= 1'b0;
      rx_stb_o   <= 1'b0;
      tx_load_o  <= 1'b0;
      tx_done_o  <= 1'b0;
      nack_hit_o <= 1'b0;
      if (stop_c) begin
        state_q  <= S_IDLE;
        acc_o    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (start_c) begin
        // access flag kept until the new address resolves
        state_q  <= S_ADDR;
        bit_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR: if (scl_rise) begin
            sh_q  <= sh_in;
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              bit_q <= '0;
              if (own_hit) begin
                acc_o   <= 1'b1;
                rd_o    <= sh_in[0];
                state_q <= S_ACK_A;
              end else if (gc_addr) begin
                acc_o    <= 1'b0;
                rd_o     <= 1'b0;
                gc_hit_o <= 1'b1;
                state_q  <= S_ACK_A;
              end else begin
                acc_o   <= 1'b0;
                state_q <= S_IDLE;
              end
            end
          end
          S_ACK_A: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            state_q  <= S_ACK_B;
          end
          S_ACK_B: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            bit_q    <= '0;
            state_q  <= rd_o ? S_TX_LOAD : S_RX;
          end
          S_RX: if (scl_rise) begin
            sh_q  <= sh_in;
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              bit_q    <= '0;
              rx_stb_o <= 1'b1;
              state_q  <= S_ACK_A;
            end
          end
          S_TX_LOAD: if (tx_pend_i) begin
            sh_q      <= tx_data_i;
            sda_oe_o  <= ~tx_data_i[DW-1];
            bit_q     <= '0;
            tx_load_o <= 1'b1;
            state_q   <= S_TX;
          end
          S_TX: if (scl_fall) begin
            if (last_bit) begin
              sda_oe_o <= 1'b0;
              state_q  <= S_TX_ACK;
            end else begin
              sh_q     <= {sh_q[DW-2:0], 1'b0};
              sda_oe_o <= ~sh_q[DW-2];
              bit_q    <= bit_q + 1'b1;
            end
          end
          S_TX_ACK: if (scl_rise) begin
            tx_done_o <= 1'b1;
            if (sda_i) begin
              nack_hit_o <= 1'b1;
              acc_o      <= 1'b0;
              state_q    <= S_IDLE;
            end else begin
              state_q <= S_TX_ACKF;
            end
          end
          S_TX_ACKF: if (scl_fall) state_q <= S_TX_LOAD;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_STOP_CLR_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> !acc_o); // R3
  AST_RSTART_KEEP_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_c && !stop_c) |=> (acc_o == $past(acc_o))); // R9
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_hit_o |-> (!sda_oe_o && !acc_o)); // R8
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          acc_i,
  input  logic          rd_i,
  input  logic          gc_hit_i,
  input  logic          rx_stb_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          tx_load_i,
  input  logic          tx_done_i,
  input  logic          nack_hit_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [AW-1:0] own_addr_o,
  output logic          gc_en_o,
  output logic          tx_pend_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_rdy_o
);
  logic [DW-1:0] rhr_q, stat;
  logic          rxr_q, gc_q, nak_q;
  logic          wr_data, rd_stat, rd_data;

  assign wr_data = reg_we_i & (reg_addr_i == REG_DATA);
  assign rd_stat = reg_re_i & (reg_addr_i == REG_STAT);
  assign rd_data = reg_re_i & (reg_addr_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr_o <= '0;
      gc_en_o    <= 1'b0;
      tx_data_o  <= '0;
      tx_pend_o  <= 1'b0;
      tx_rdy_o   <= 1'b1;
      rhr_q      <= '0;
      rxr_q      <= 1'b0;
      gc_q       <= 1'b0;
      nak_q      <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_OWN)  own_addr_o <= reg_wdata_i[AW-1:0];
      if (reg_we_i && reg_addr_i == REG_CTRL) gc_en_o    <= reg_wdata_i[0];
      // a software load wins over a same-cycle engine event
      if (wr_data) begin
        tx_data_o <= reg_wdata_i;
        tx_pend_o <= 1'b1;
        tx_rdy_o  <= 1'b0;
      end else begin
        if (tx_load_i) tx_pend_o <= 1'b0;
        if (tx_done_i) tx_rdy_o  <= 1'b1;
      end
      if (rx_stb_i) begin
        rhr_q <= rx_data_i;
        rxr_q <= 1'b1;
      end else if (rd_data) begin
        rxr_q <= 1'b0;
      end
      if (gc_hit_i)     gc_q <= 1'b1;
      else if (rd_stat) gc_q <= 1'b0;
      if (nack_hit_i)   nak_q <= 1'b1;
      else if (rd_stat) nak_q <= 1'b0;
    end
  end

  always_comb begin
    stat         = '0;
    stat[ST_ACC] = acc_i;
    stat[ST_RD]  = rd_i;
    stat[ST_GC]  = gc_q;
    stat[ST_TXR] = tx_rdy_o;
    stat[ST_RXR] = rxr_q;
    stat[ST_NAK] = nak_q;
    unique case (reg_addr_i)
      REG_OWN:  reg_rdata_o = {{(DW-AW){1'b0}}, own_addr_o};
      REG_CTRL: reg_rdata_o = {{(DW-1){1'b0}}, gc_en_o};
      REG_STAT: reg_rdata_o = stat;
      default:  reg_rdata_o = rhr_q;
    endcase
  end

  AST_TXRDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !tx_rdy_o); // R6
  AST_TXRDY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_rdy_o) |-> $past(tx_done_i)); // R6
  AST_GC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !gc_hit_i) |=> !gc_q); // R4
  AST_NACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !nack_hit_i) |=> !nak_q); // R8
  AST_RXRDY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_stb_i) |=> !rxr_q); // R5
endmodule

// File: rtl/i2c_target_stat.sv
module i2c_target_stat #(
  parameter int ADDR_W   = 7,
  parameter int FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W:0]   reg_wdata_i,
  output logic [ADDR_W:0]   reg_rdata_o
);
  localparam int DW = ADDR_W + 1;

  logic [1:0]        line_f;
  logic [ADDR_W-1:0] own_addr;
  logic [DW-1:0]     tx_data, rx_data;
  logic gc_en, tx_pend, tx_rdy, acc, rd, gc_hit, rx_stb, tx_load, tx_done, nack_hit;

  i2c_tgt_filt #(.WIDTH(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i ({scl_i, sda_i}),
    .dout_o(line_f)
  );

  i2c_tgt_engine #(.AW(ADDR_W), .DW(DW)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (line_f[1]),
    .sda_i     (line_f[0]),
    .own_addr_i(own_addr),
    .gc_en_i   (gc_en),
    .tx_pend_i (tx_pend),
    .tx_data_i (tx_data),
    .sda_oe_o  (sda_oe_o),
    .scl_oe_o  (scl_oe_o),
    .acc_o     (acc),
    .rd_o      (rd),
    .gc_hit_o  (gc_hit),
    .rx_stb_o  (rx_stb),
    .rx_data_o (rx_data),
    .tx_load_o (tx_load),
    .tx_done_o (tx_done),
    .nack_hit_o(nack_hit)
  );

  i2c_tgt_regs #(.AW(ADDR_W), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_re_i   (reg_re_i),
    .reg_wdata_i(reg_wdata_i),
    .acc_i      (acc),
    .rd_i       (rd),
    .gc_hit_i   (gc_hit),
    .rx_stb_i   (rx_stb),
    .rx_data_i  (rx_data),
    .tx_load_i  (tx_load),
    .tx_done_i  (tx_done),
    .nack_hit_i (nack_hit),
    .reg_rdata_o(reg_rdata_o),
    .own_addr_o (own_addr),
    .gc_en_o    (gc_en),
    .tx_pend_o  (tx_pend),
    .tx_data_o  (tx_data),
    .tx_rdy_o   (tx_rdy)
  );

  AST_HOLD_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> tx_rdy); // R7
endmodule

// File: tb/i2c_target_stat_tb_top.sv
module i2c_target_stat_tb_top;
  localparam int Q = 16;
  localparam logic [1:0] A_OWN = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;
  // {address byte, gc enable, exp ack, exp access, exp direction, exp gc}
  localparam logic [12:0] VEC [7] = '{
    {8'h74, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h75, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h76, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic [1:0] r_addr = '0;
  logic r_we = 1'b0, r_re = 1'b0;
  logic [7:0] r_wdata = '0, r_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] ab, s, d;
  logic ge, eack, eacc, erd, egc, a;
  string tag;

  always #2 clk = ~clk;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_target_stat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_addr_i(r_addr),
    .reg_we_i(r_we), .reg_re_i(r_re), .reg_wdata_i(r_wdata), .reg_rdata_o(r_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] ad, input logic [7:0] v);
    @(negedge clk); r_addr = ad; r_wdata = v; r_we = 1'b1;
    @(negedge clk); r_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] ad, output logic [7:0] v);
    @(negedge clk); r_addr = ad; r_re = 1'b1;
    #1 v = r_rdata;
    @(negedge clk); r_re = 1'b0;
  endtask

  task automatic bbit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(1);
    while (!scl_bus) tick(1);
    tick(Q); r = sda_bus;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bwrite(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bbit(v[i], r);
    bbit(1'b1, r);
    ack = ~r;
  endtask

  task automatic bread(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bbit(1'b1, r);
      v[i] = r;
    end
    bbit(~mack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(3);
    // R10 reset state
    chk(!sda_oe && !scl_oe, "R10", "lines released", {sda_oe, scl_oe}, 0);
    reg_rd(A_STAT, s);
    chk(s == 8'h08, "R10", "status after reset", s, 8'h08);
    reg_wr(A_OWN, 8'h3A);

    // address table: R1 R2 R3 R4
    for (int i = 0; i < 7; i++) begin
      {ab, ge, eack, eacc, erd, egc} = VEC[i];
      tag = egc ? "R4" : (eacc ? "R1" : "R2");
      reg_wr(A_CTRL, {7'd0, ge});
      if (eack && ab[0]) reg_wr(A_DATA, 8'h96);
      bstart();
      bwrite(ab, a);
      chk(a == eack, tag, "address ack", a, eack);
      reg_rd(A_STAT, s);
      chk(s[0] == eacc, tag, "access bit", s[0], eacc);
      if (eacc) chk(s[1] == erd, "R1", "direction bit", s[1], erd);
      chk(s[2] == egc, "R4", "general call bit", s[2], egc);
      if (eack && ab[0]) begin
        bread(1'b0, d);
        chk(d == 8'h96, "R6", "sent byte", d, 8'h96);
      end
      bstop(); tick(10);
      reg_rd(A_STAT, s);
      chk(s[0] == 1'b0, "R3", "access after stop", s[0], 0);
      chk(s[2] == 1'b0, "R4", "gc cleared by read", s[2], 0);
    end
    reg_wr(A_CTRL, 8'h00);
    reg_rd(A_STAT, s);

    // R5 receive
    bstart(); bwrite(8'h74, a);
    bwrite(8'hA5, a);
    chk(a, "R5", "data byte ack", a, 1);
    reg_rd(A_STAT, s);
    chk(s[4], "R5", "rx ready set", s[4], 1);
    reg_rd(A_DATA, d);
    chk(d == 8'hA5, "R5", "rx data", d, 8'hA5);
    reg_rd(A_STAT, s);
    chk(!s[4], "R5", "rx ready cleared", s[4], 0);
    bwrite(8'h3C, a);
    reg_rd(A_DATA, d);
    chk(a && d == 8'h3C, "R5", "second rx data", d, 8'h3C);
    bstop(); tick(10);

    // R9 repeated start
    bstart(); bwrite(8'h74, a);
    bstart();
    reg_rd(A_STAT, s);
    chk(s[0], "R9", "access kept over rstart", s[0], 1);
    bwrite(8'h76, a);
    chk(!a, "R9", "mismatch after rstart nacked", a, 0);
    reg_rd(A_STAT, s);
    chk(!s[0], "R9", "access follows new compare", s[0], 0);
    bstart(); bwrite(8'h74, a);
    reg_rd(A_STAT, s);
    chk(a && s[0], "R9", "access after rematch", s[0], 1);
    bstop(); tick(10);

    // R6 R7 R8 transmit
    reg_wr(A_DATA, 8'hC3);
    reg_rd(A_STAT, s);
    chk(!s[3], "R6", "tx ready after write", s[3], 0);
    bstart(); bwrite(8'h75, a);
    bread(1'b1, d);
    chk(d == 8'hC3, "R6", "sent byte msb first", d, 8'hC3);
    tick(20);
    chk(scl_oe, "R7", "clock held while empty", scl_oe, 1);
    reg_rd(A_STAT, s);
    chk(s[3] && s[0] && s[1], "R6", "tx ready after ack", s, 8'h0B);
    reg_wr(A_DATA, 8'h5E);
    tick(2);
    chk(!scl_oe, "R7", "clock released after load", scl_oe, 0);
    bread(1'b0, d);
    chk(d == 8'h5E, "R6", "second sent byte", d, 8'h5E);
    reg_rd(A_STAT, s);
    chk((s & 8'h29) == 8'h28, "R8", "nack set access clear", s & 8'h29, 8'h28);
    reg_wr(A_DATA, 8'h00);
    bread(1'b0, d);
    chk(d == 8'hFF && !scl_oe, "R8", "no drive after nack", d, 8'hFF);
    reg_rd(A_STAT, s);
    chk(!s[5], "R8", "nack cleared by read", s[5], 0);
    bstop(); tick(10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule